// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-on to a usable state. After reset it drives the command pins (chip select, row strobe, column strobe, write enable, address, bank and clock enable) through a fixed series of steps. First it holds an idle period of no-operation commands. Then it closes all banks, issues a group of auto-refresh commands, and finally loads the device's mode register. Every wait between steps is counted in clocks. Each count is derived from a nanosecond minimum and the clock period, both given as parameters.

When the last wait has expired, the sequencer raises `init_done` and keeps the command bus idle. A memory controller then takes over the pins. The refresh count and the mode word are also parameters. A reset at any time restarts the whole sequence from the idle period.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is held, the command is NOP, clock enable is high and `init_done` is low. Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, precharge=0010, auto-refresh=0001 and mode set=0000.
- R2: After the last clock edge with reset low, NOP is presented for exactly P cycles, where P is the pause minimum rounded up to whole clocks.
- R3: In cycle P a single precharge-all command is issued, with address bit 10 high and all other address bits and the bank bits low.
- R4: The number of auto-refresh commands is the refresh parameter, raised to 8 when the parameter is set lower.
- R5: The first refresh follows the precharge by exactly the precharge-time minimum in clocks. Every cycle between them is NOP.
- R6: Consecutive refreshes, and the last refresh and the mode set, are spaced by exactly the row-cycle minimum in clocks. Every cycle between them is NOP.
- R7: The mode set is the final command. It carries the low 7 bits of the mode word on address bits 6..0, with all higher address bits and the bank bits low.
- R8: `init_done` rises exactly 3 cycles after the mode set. It then stays high while the bus stays NOP.
- R9: Clock enable is high in every cycle of the sequence and afterwards.
- R10: Each nanosecond minimum becomes ceil(ns*1000 / period_ps) clocks. The two gaps are never shorter than 2 clocks, and the pause is never shorter than 1 clock.
- R11: A reset asserted in the middle of the sequence restarts it from the pause, with the same timing as after power-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Synchronous reset, active low |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BANK_W | Bank select |
| init_done | output | 1 | High once normal traffic may begin |

## Verification
The bench runs two instances side by side, and every output is compared against an arithmetic schedule in every cycle of the sequence.

The first instance uses a 10 ns period, whose nanosecond minimums divide evenly. It asks for 9 refreshes and has a mode word with reserved bits set, so it shows the refresh count taken as given and the reserved bits cleared. The second instance uses a 7 ns period, which forces every conversion to round up, and asks for only 3 refreshes, which must be raised to 8.

A reset in the middle of the refresh phase, followed by a second full sweep, tells a true restart apart from a resumed sequence.

// File: rtl/sdram_init_pkg.sv
// Package: shared command encodings, FSM states and cycle-conversion helpers
// for the SDRAM power-up sequencer. Assumes periods are given in picoseconds.
package sdram_init_pkg;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRE,
        ST_WAIT_PRE,
        ST_REF,
        ST_WAIT_REF,
        ST_MRS,
        ST_WAIT_MRS,
        ST_DONE
    } init_state_e;

    // Round a nanosecond minimum up to whole clocks of period_ps
    function automatic int ns_to_clks(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    // Raise a value to a floor
    function automatic int at_least(input int v, input int floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Down-counter that times the waits between sequencer steps.
// Assumes: load has priority; the count stops at zero; zero_o is high on zero.
module sdram_init_timer #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] count_q;

    // Load a new wait, or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RESET_VAL);
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign zero_o = (count_q == '0);

    // R10: once at zero, the count stays there unless a new wait is loaded
    a_r10_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sdram_init_refcnt.sv
// Counts the auto-refresh commands still to be issued.
// Assumes: dec_i is pulsed once per refresh command and never after the last.
module sdram_init_refcnt #(
    parameter int NUM_REFS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_i,
    output logic none_left_o
);

    localparam int W = $clog2(NUM_REFS + 1);

    logic [W-1:0] left_q;

    // Reload on reset, decrement on each refresh issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= W'(NUM_REFS);
        end else if (dec_i) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign none_left_o = (left_q == '0);

    // R4: no refresh is issued beyond the required count
    a_r4_no_extra_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> !none_left_o);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
// Turns the requested command into pin levels, address and bank.
// Assumes: the mode word keeps only its MODE_BITS low bits; the rest are reserved.
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          BANK_W    = 2,
    parameter int          AP_BIT    = 10,
    parameter int          MODE_BITS = 7,
    parameter [ADDR_W-1:0] MODE_WORD = '0
) (
    input  sd_cmd_e           cmd_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] ba_o
);

    // Drive the strobes and place the operand for precharge or mode set
    always_comb begin
        {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_i;
        addr_o = '0;
        ba_o   = '0;
        case (cmd_i)
            CMD_PRE: addr_o[AP_BIT] = 1'b1;
            CMD_MRS: addr_o[MODE_BITS-1:0] = MODE_WORD[MODE_BITS-1:0];
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
// SDRAM power-up sequencer: pause, precharge-all, N auto-refreshes, mode set,
// then init_done. All gaps are clocks derived from ns minimums and CLK_PERIOD_PS.
// Assumes: synchronous active-low reset; the outputs are decoded from the state register.
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int          CLK_PERIOD_PS = 10000,
    parameter int          PAUSE_NS      = 200000,
    parameter int          TRP_NS        = 30,
    parameter int          TRC_NS        = 90,
    parameter int          MRD_CLKS      = 3,
    parameter int          REFRESH_COUNT = 8,
    parameter int          ADDR_W        = 12,
    parameter int          BANK_W        = 2,
    parameter [ADDR_W-1:0] MODE_WORD     = 12'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              init_done
);

    localparam int PAUSE_CLKS = at_least(ns_to_clks(PAUSE_NS, CLK_PERIOD_PS), 1);
    localparam int TRP_CLKS   = at_least(ns_to_clks(TRP_NS, CLK_PERIOD_PS), 2);
    localparam int TRC_CLKS   = at_least(ns_to_clks(TRC_NS, CLK_PERIOD_PS), 2);
    localparam int MRD_GAP    = at_least(MRD_CLKS, 2);
    localparam int NUM_REFS   = at_least(REFRESH_COUNT, 8);
    localparam int MAX_LOAD   = at_least(PAUSE_CLKS, at_least(TRP_CLKS, at_least(TRC_CLKS, MRD_GAP)));
    localparam int CNT_W      = $clog2(MAX_LOAD + 1);
    localparam int AP_BIT     = 10;
    localparam int MODE_BITS  = 7;

    init_state_e       state_q, state_d;
    sd_cmd_e           cmd;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_zero;
    logic              ref_dec;
    logic              refs_none;

    sdram_init_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (PAUSE_CLKS - 1)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    sdram_init_refcnt #(
        .NUM_REFS (NUM_REFS)
    ) refcnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_i       (ref_dec),
        .none_left_o (refs_none)
    );

    // State register; any reset returns to the pause
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PAUSE;
        else        state_q <= state_d;
    end

    // Next state and wait loads; each command state lasts one cycle
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        ref_dec = 1'b0;
        case (state_q)
            ST_PAUSE:    if (t_zero) state_d = ST_PRE;
            ST_PRE: begin
                t_load  = 1'b1;
                t_val   = CNT_W'(TRP_CLKS - 2);
                state_d = ST_WAIT_PRE;
            end
            ST_WAIT_PRE: if (t_zero) state_d = ST_REF;
            ST_REF: begin
                t_load  = 1'b1;
                t_val   = CNT_W'(TRC_CLKS - 2);
                ref_dec = 1'b1;
                state_d = ST_WAIT_REF;
            end
            ST_WAIT_REF: if (t_zero) state_d = refs_none ? ST_MRS : ST_REF;
            ST_MRS: begin
                t_load  = 1'b1;
                t_val   = CNT_W'(MRD_GAP - 2);
                state_d = ST_WAIT_MRS;
            end
            ST_WAIT_MRS: if (t_zero) state_d = ST_DONE;
            default:     state_d = ST_DONE;
        endcase
    end

    // Command requested by the current state
    always_comb begin
        case (state_q)
            ST_PRE:  cmd = CMD_PRE;
            ST_REF:  cmd = CMD_REF;
            ST_MRS:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

    sdram_init_cmd_enc #(
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W),
        .AP_BIT    (AP_BIT),
        .MODE_BITS (MODE_BITS),
        .MODE_WORD (MODE_WORD)
    ) enc_i (
        .cmd_i   (cmd),
        .cs_n_o  (sd_cs_n),
        .ras_n_o (sd_ras_n),
        .cas_n_o (sd_cas_n),
        .we_n_o  (sd_we_n),
        .addr_o  (sd_addr),
        .ba_o    (sd_ba)
    );

    assign sd_cke    = 1'b1;
    assign init_done = (state_q == ST_DONE);

    logic pin_nop, pin_pre, pin_mrs;
    assign pin_nop = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111);
    assign pin_pre = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010);
    assign pin_mrs = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000);

    // R3: precharge selects all banks through address bit 10
    a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pre |-> (sd_addr[AP_BIT] && sd_ba == '0));

    // R7: the mode set leaves reserved address bits and bank bits low
    a_r7_mode_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mrs |-> (sd_addr[ADDR_W-1:MODE_BITS] == '0 && sd_ba == '0));

    // R5: every command is followed by at least one NOP
    a_r5_cmd_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_nop |=> pin_nop);

    // R8: init_done rises exactly 3 cycles after the mode set
    a_r8_done_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(pin_mrs, MRD_GAP));

    // R8: once done, it stays done and the bus stays idle
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && pin_nop));

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
// Bench: two configurations swept cycle by cycle against an arithmetic schedule.
module sdram_pwrup_seq_tb_top;

    localparam int A_PER = 10000;
    localparam int A_PAUSE = 300;
    localparam int A_REFS = 9;
    localparam logic [11:0] A_MODE = 12'hFB2;
    localparam int B_PER = 7000;
    localparam int B_PAUSE = 250;
    localparam int B_REFS = 3;
    localparam logic [11:0] B_MODE = 12'h023;
    localparam int SWEEP = 170;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;

    always #5 clk = ~clk;

    logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [11:0] a_addr;
    logic [1:0]  a_ba;
    logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [11:0] b_addr;
    logic [1:0]  b_ba;

    sdram_pwrup_seq #(
        .CLK_PERIOD_PS (A_PER), .PAUSE_NS (A_PAUSE), .REFRESH_COUNT (A_REFS),
        .MODE_WORD (A_MODE)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sd_cke (a_cke), .sd_cs_n (a_cs),
        .sd_ras_n (a_ras), .sd_cas_n (a_cas), .sd_we_n (a_we),
        .sd_addr (a_addr), .sd_ba (a_ba), .init_done (a_done)
    );

    sdram_pwrup_seq #(
        .CLK_PERIOD_PS (B_PER), .PAUSE_NS (B_PAUSE), .REFRESH_COUNT (B_REFS),
        .MODE_WORD (B_MODE)
    ) dut_b_i (
        .clk (clk), .rst_n (rst_n), .sd_cke (b_cke), .sd_cs_n (b_cs),
        .sd_ras_n (b_ras), .sd_cas_n (b_cas), .sd_we_n (b_we),
        .sd_addr (b_addr), .sd_ba (b_ba), .init_done (b_done)
    );

    function automatic int clks(input int ns, input int ps, input int floor_v);
        int v;
        v = (ns * 1000 + ps - 1) / ps;
        return (v < floor_v) ? floor_v : v;
    endfunction

    // Expected command code at cycle t of a sequence
    function automatic logic [3:0] exp_cmd(input int t, input int p, input int trp,
                                           input int trc, input int nref);
        if (t == p) return 4'b0010;
        for (int i = 0; i < nref; i++)
            if (t == p + trp + i * trc) return 4'b0001;
        if (t == p + trp + nref * trc) return 4'b0000;
        return 4'b0111;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // Check one instance at cycle t of its sequence
    task automatic check_cycle(input int t, input int per, input int pause,
                               input int refs_req, input logic [11:0] mode,
                               input logic cke, input logic [3:0] c,
                               input logic [11:0] addr, input logic [1:0] ba,
                               input logic done);
        int p, trp, trc, nref, m;
        logic [3:0] e;
        logic [11:0] ea;
        p = clks(pause, per, 1);          // R10
        trp = clks(30, per, 2);
        trc = clks(90, per, 2);
        nref = (refs_req < 8) ? 8 : refs_req;
        m = p + trp + nref * trc;
        e = exp_cmd(t, p, trp, trc, nref);
        ea = 12'h000;
        if (e == 4'b0010) ea = 12'h400;
        if (e == 4'b0000) ea = {5'b0, mode[6:0]};
        if (t < p)
            check(c == e, "R2 pause NOP", c, e);
        else if (t == p)
            check(c == e, "R3 precharge", c, e);
        else if (t < p + trp)
            check(c == e, "R5 gap after precharge", c, e);
        else if (t < m)
            check(c == e, "R4 R6 refresh schedule", c, e);
        else if (t == m)
            check(c == e, "R7 mode set last", c, e);
        else
            check(c == e, "R8 idle after mode set", c, e);
        check({addr, ba} == {ea, 2'b00}, (e == 4'b0000) ? "R7 mode operand" : "R3 address",
              int'({addr, ba}), int'({ea, 2'b00}));
        check(done == (t >= m + 3), "R8 init_done timing", done, (t >= m + 3));
        check(cke == 1'b1, "R9 cke high", cke, 1);
    endtask

    task automatic sweep();
        for (int t = 0; t < SWEEP; t++) begin
            #1;
            check_cycle(t, A_PER, A_PAUSE, A_REFS, A_MODE, a_cke,
                        {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba, a_done);
            check_cycle(t, B_PER, B_PAUSE, B_REFS, B_MODE, b_cke,
                        {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba, b_done);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({a_cs, a_ras, a_cas, a_we} == 4'b0111, "R1 reset NOP", {a_cs, a_ras, a_cas, a_we}, 4'b0111);
        check({b_cs, b_ras, b_cas, b_we} == 4'b0111, "R1 reset NOP", {b_cs, b_ras, b_cas, b_we}, 4'b0111);
        check(a_cke && b_cke, "R1 reset cke", a_cke, 1);
        check(!a_done && !b_done, "R1 reset done low", a_done, 0);
        rst_n = 1'b1;
        sweep();
        // R11: reset in the refresh phase, then a full sweep from the start
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!a_done && !b_done, "R11 done cleared by reset", a_done, 0);
        rst_n = 1'b1;
        sweep();
        finish_run();
    end

endmodule